// File: doc/BRIEF.md
# Request-Driven Single-Channel DMA Engine

This block is one direct-mode DMA channel. Software programs a source address, a destination address, a transfer count, an optional watermark and a control word through a small register port. Once the channel is enabled, each request pulse from the attached peripheral makes it move one item from source to destination over a valid/ready memory port. Each move is a read beat followed by a write beat. An item is a byte, a 16-bit word or a 32-bit quad. The source and destination addresses each stay fixed, step up or step down by the item size.

The buffer ends when the remaining count reaches zero or when the peripheral raises its end-of-frame request, whichever comes first. At that point the channel clears its own enable. It can copy a peripheral status byte into the command field of its control word, and it raises a sticky interrupt flag that software clears by writing a one. A nonzero watermark can also raise the interrupt part way through the buffer.

Top module: `dma_direct_ch`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `mem_valid` is low. The register offsets are 0 source address, 1 destination address, 2 count, 3 watermark, 4 control and 5 status. Status bit 0 is the interrupt flag and status bit 1 is busy.
- R2: Control bits [2:1] select the item size: 0 is a byte, 1 is a 2-byte word, 2 is a 4-byte quad and 3 is treated as a byte. The write data is the read data masked to that size. Each address step equals the item size in bytes.
- R3: Control bits [4:3] set the destination mode and bits [6:5] set the source mode, each chosen on its own: 0 or 3 fixed, 1 increment, 2 decrement.
- R4: Each accepted request makes exactly one read beat and then one write beat. The count drops by one when the write is acknowledged. A request that arrives while a move is in flight is ignored.
- R5: When the count reaches zero after a write, control bit 0 (enable) is cleared in that same clock edge.
- R6: An end-of-frame request that comes together with a request lets that one move finish and then ends the buffer. An end-of-frame request on its own ends the buffer at once, with no memory access and no change to the count.
- R7: If control bit 8 (EOF buffer) is set when the buffer ends, `periph_status` is copied into control bits [23:16]. Those bits also drive `periph_cmd`.
- R8: The interrupt flag is sticky. It is set at buffer end when control bit 7 (interrupt enable) is set, and also whenever the buffer was ended by end-of-frame. Writing 1 to status bit 0 clears it, writing 0 leaves it unchanged, and a set in the same cycle as a clear wins. `irq` follows the flag.
- R9: With interrupt enable set and a nonzero watermark, the flag is set when the count after a write equals the watermark. A watermark of zero never raises this interrupt.
- R10: Requests are ignored while enable is clear. The channel starts only on a request that comes after enable has been written. A request while enabled with a count of zero ends the buffer without any memory access.
- R11: Control bits 9, 10 and 11 (loop, descriptor, halt) are not stored, always read zero and do not change how a transfer behaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| dma_req | input | 1 | Peripheral transfer request |
| dma_req_eof | input | 1 | Peripheral end-of-frame request |
| periph_status | input | CMD_W | Peripheral status captured at buffer end |
| periph_cmd | output | CMD_W | Command field presented to the peripheral |
| mem_valid | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 for a write beat, 0 for a read beat |
| mem_size | output | 2 | Item size code (0 byte, 1 word, 2 quad) |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Write data, low bytes significant |
| mem_ready | input | 1 | Memory accepts or completes the beat |
| mem_rdata | input | 32 | Read data, valid with mem_ready on a read |
| irq | output | 1 | Sticky interrupt flag |

## Verification
A request is sampled on one rising edge. With a zero-wait memory the read beat completes on the next edge and the write beat on the edge after that, so the new count, addresses, enable, captured status and interrupt flag appear after that third edge. An end-of-frame request on its own, or a request with a count of zero, takes effect on the same edge that samples it. The bench drives inputs at falling edges and polls the busy bit at falling edges until the move is over, then reads the registers back, so every sample falls after the edge on which its result is due. The scenario that checks a request arriving while a move is in flight stretches the memory with wait states so that the second request lands inside the move.

// File: rtl/dma_direct_pkg.sv
// Package: shared types, register offsets and size helpers for the
// direct-mode DMA channel. Assumes a 32-bit register and data path.
package dma_direct_pkg;

    localparam logic [2:0] REG_SRC  = 3'd0;
    localparam logic [2:0] REG_DST  = 3'd1;
    localparam logic [2:0] REG_CNT  = 3'd2;
    localparam logic [2:0] REG_WMK  = 3'd3;
    localparam logic [2:0] REG_CTL  = 3'd4;
    localparam logic [2:0] REG_STAT = 3'd5;

    localparam int CTL_CMD_LSB = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic       en;
        logic [1:0] size;
        logic [1:0] dmode;
        logic [1:0] smode;
        logic       ie;
        logic       eofbuf;
    } ctl_t;

    // Normalise the size code: code 3 behaves as a byte.
    function automatic logic [1:0] size_eff(input logic [1:0] code);
        return (code == 2'd3) ? 2'd0 : code;
    endfunction

    // Number of bytes in one item.
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (size_eff(code))
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    // Byte-lane mask for one item.
    function automatic logic [31:0] size_mask(input logic [1:0] code);
        case (size_eff(code))
            2'd1:    return 32'h0000_FFFF;
            2'd2:    return 32'hFFFF_FFFF;
            default: return 32'h0000_00FF;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
// Address stepper: computes the address after one item for a given
// mode (0/3 fixed, 1 increment, 2 decrement) and item size.
// Purely combinational; wraps modulo 2**ADDR_W.
module dma_addr_step
    import dma_direct_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [1:0]        mode,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] nxt
);
    logic [ADDR_W-1:0] step;

    // Step distance equals the item width in bytes.
    assign step = ADDR_W'(size_bytes(size));

    // Select the next address from the mode.
    always_comb begin
        case (mode)
            2'd1:    nxt = cur + step;
            2'd2:    nxt = cur - step;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/dma_ch_regs.sv
// Register file of the channel: source, destination, count, watermark,
// control word and sticky interrupt flag. Engine updates take priority
// over software writes in the same cycle; a buffer end clears enable and
// optionally captures the peripheral status. Assumes ADDR_W, LEN_W <= 32
// and CMD_W <= 16.
module dma_ch_regs
    import dma_direct_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int CMD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              busy,
    input  logic              xfer_done,
    input  logic [ADDR_W-1:0] nsrc,
    input  logic [ADDR_W-1:0] ndst,
    input  logic [LEN_W-1:0]  nlen,
    input  logic              buf_end,
    input  logic              irq_set,
    input  logic [CMD_W-1:0]  per_status,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [LEN_W-1:0]  len_q,
    output logic [LEN_W-1:0]  wm_q,
    output ctl_t              ctl_q,
    output logic [CMD_W-1:0]  cmd_q,
    output logic              irq_q
);
    logic clr_irq;

    // Software write-1-to-clear of the interrupt flag.
    assign clr_irq = cfg_wr && (cfg_addr == REG_STAT) && cfg_wdata[0];

    // Register state: software writes, then engine updates override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            len_q <= '0;
            wm_q  <= '0;
            ctl_q <= '0;
            cmd_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (cfg_wr) begin
                case (cfg_addr)
                    REG_SRC: src_q <= cfg_wdata[ADDR_W-1:0];
                    REG_DST: dst_q <= cfg_wdata[ADDR_W-1:0];
                    REG_CNT: len_q <= cfg_wdata[LEN_W-1:0];
                    REG_WMK: wm_q  <= cfg_wdata[LEN_W-1:0];
                    REG_CTL: begin
                        ctl_q.en     <= cfg_wdata[0];
                        ctl_q.size   <= cfg_wdata[2:1];
                        ctl_q.dmode  <= cfg_wdata[4:3];
                        ctl_q.smode  <= cfg_wdata[6:5];
                        ctl_q.ie     <= cfg_wdata[7];
                        ctl_q.eofbuf <= cfg_wdata[8];
                        cmd_q        <= cfg_wdata[CTL_CMD_LSB +: CMD_W];
                    end
                    default: ;
                endcase
            end
            if (clr_irq) begin
                irq_q <= 1'b0;
            end
            if (xfer_done) begin
                src_q <= nsrc;
                dst_q <= ndst;
                len_q <= nlen;
            end
            if (buf_end) begin
                ctl_q.en <= 1'b0;
                if (ctl_q.eofbuf) begin
                    cmd_q <= per_status;
                end
            end
            if (irq_set) begin
                irq_q <= 1'b1;
            end
        end
    end

    // Read multiplexer; reserved control bits always return zero.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            REG_SRC: cfg_rdata[ADDR_W-1:0] = src_q;
            REG_DST: cfg_rdata[ADDR_W-1:0] = dst_q;
            REG_CNT: cfg_rdata[LEN_W-1:0]  = len_q;
            REG_WMK: cfg_rdata[LEN_W-1:0]  = wm_q;
            REG_CTL: begin
                cfg_rdata[0]   = ctl_q.en;
                cfg_rdata[2:1] = ctl_q.size;
                cfg_rdata[4:3] = ctl_q.dmode;
                cfg_rdata[6:5] = ctl_q.smode;
                cfg_rdata[7]   = ctl_q.ie;
                cfg_rdata[8]   = ctl_q.eofbuf;
                cfg_rdata[CTL_CMD_LSB +: CMD_W] = cmd_q;
            end
            REG_STAT: begin
                cfg_rdata[0] = irq_q;
                cfg_rdata[1] = busy;
            end
            default: cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_ch_seq.sv
// Transfer sequencer: accepts one request while idle and enabled, runs a
// read beat then a write beat on the valid/ready port, and decides buffer
// end, count update and interrupt requests. Requests are not queued while
// a move is in flight. Assumes mem_rdata is valid with mem_ready.
module dma_ch_seq
    import dma_direct_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic [LEN_W-1:0]  len,
    input  logic [LEN_W-1:0]  wm,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic              req,
    input  logic              req_eof,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [1:0]        mem_size,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              busy,
    output logic              xfer_done,
    output logic [LEN_W-1:0]  nlen,
    output logic              buf_end,
    output logic              irq_set
);
    seq_state_e        state_q, state_d;
    logic [31:0]       data_q;
    logic              eof_pend_q;
    logic              start;
    logic              quick_end;
    logic              last;
    logic              wm_hit;

    // Start a move on a request while enabled with items left.
    assign start     = (state_q == ST_IDLE) && ctl.en && req && (len != '0);
    // End at once on lone end-of-frame or on a request with nothing left.
    assign quick_end = (state_q == ST_IDLE) && ctl.en && !start && (req || req_eof);

    assign nlen   = len - LEN_W'(1);
    assign last   = (nlen == '0) || eof_pend_q;
    assign wm_hit = ctl.ie && (wm != '0) && (nlen == wm);

    // Next-state logic of the read/write sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start)     state_d = ST_RD;
            ST_RD:   if (mem_ready) state_d = ST_WR;
            ST_WR:   if (mem_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State, captured read data and pending end-of-frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            data_q     <= '0;
            eof_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                eof_pend_q <= req_eof;
            end
            if ((state_q == ST_RD) && mem_ready) begin
                data_q <= mem_rdata & size_mask(ctl.size);
            end
        end
    end

    // Memory port drive.
    always_comb begin
        mem_valid = (state_q != ST_IDLE);
        mem_we    = (state_q == ST_WR);
        mem_size  = size_eff(ctl.size);
        mem_addr  = (state_q == ST_WR) ? dst : src;
        mem_wdata = data_q;
    end

    // Completion events towards the register file.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        xfer_done = (state_q == ST_WR) && mem_ready;
        buf_end   = quick_end || (xfer_done && last);
        irq_set   = (quick_end && (ctl.ie || req_eof))
                  || (xfer_done && last && (ctl.ie || eof_pend_q))
                  || (xfer_done && wm_hit);
    end
endmodule

// File: rtl/dma_direct_ch.sv
// Top of the direct-mode DMA channel: register file, transfer sequencer
// and one address stepper per direction (generated). Assumes a single
// memory port shared by read and write beats.
module dma_direct_ch
    import dma_direct_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int CMD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              dma_req,
    input  logic              dma_req_eof,
    input  logic [CMD_W-1:0]  periph_status,
    output logic [CMD_W-1:0]  periph_cmd,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [1:0]        mem_size,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              irq
);
    localparam int N_PTR = 2;   // index 0 source, index 1 destination

    ctl_t              ctl;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [LEN_W-1:0]  len_q, wm_q, nlen;
    logic [CMD_W-1:0]  cmd_q;
    logic              busy, xfer_done, buf_end, irq_set, irq_q;
    logic [ADDR_W-1:0] ptr_cur [N_PTR];
    logic [ADDR_W-1:0] ptr_nxt [N_PTR];
    logic [1:0]        ptr_mode [N_PTR];

    assign ptr_cur[0]  = src_q;
    assign ptr_cur[1]  = dst_q;
    assign ptr_mode[0] = ctl.smode;
    assign ptr_mode[1] = ctl.dmode;

    // One address stepper per pointer.
    for (genvar g = 0; g < N_PTR; g++) begin : g_step
        dma_addr_step #(.ADDR_W(ADDR_W)) u_step (
            .cur  (ptr_cur[g]),
            .mode (ptr_mode[g]),
            .size (ctl.size),
            .nxt  (ptr_nxt[g])
        );
    end

    dma_ch_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CMD_W(CMD_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .busy       (busy),
        .xfer_done  (xfer_done),
        .nsrc       (ptr_nxt[0]),
        .ndst       (ptr_nxt[1]),
        .nlen       (nlen),
        .buf_end    (buf_end),
        .irq_set    (irq_set),
        .per_status (periph_status),
        .src_q      (src_q),
        .dst_q      (dst_q),
        .len_q      (len_q),
        .wm_q       (wm_q),
        .ctl_q      (ctl),
        .cmd_q      (cmd_q),
        .irq_q      (irq_q)
    );

    dma_ch_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .len       (len_q),
        .wm        (wm_q),
        .src       (src_q),
        .dst       (dst_q),
        .req       (dma_req),
        .req_eof   (dma_req_eof),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_size  (mem_size),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ready (mem_ready),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .xfer_done (xfer_done),
        .nlen      (nlen),
        .buf_end   (buf_end),
        .irq_set   (irq_set)
    );

    assign periph_cmd = cmd_q;
    assign irq        = irq_q;
endmodule

// File: rtl/dma_direct_chk.sv
// Checker for the DMA channel: protocol and state properties, bound to
// every instance of the top module.
module dma_direct_chk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_valid,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              en,
    input logic [LEN_W-1:0]  len,
    input logic              irq,
    input logic              clr
);
    // R4: a completed read beat is followed by a write beat.
    p_rd_then_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we && mem_ready) |=> (mem_valid && mem_we));

    // R4: a beat holds address and direction until accepted.
    p_beat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

    // R4: an acknowledged write lowers the count by exactly one.
    p_cnt_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we && mem_ready) |=> (len == $past(len) - {{(LEN_W-1){1'b0}}, 1'b1}));

    // R5: the write that empties the count also drops enable.
    p_last_drops_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we && mem_ready && (len == {{(LEN_W-1){1'b0}}, 1'b1})) |=> !en);

    // R10: an idle, disabled channel issues no access in the next cycle.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !en) |=> !mem_valid);

    // R8: the interrupt flag only falls through a software clear.
    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr) |=> irq);
endmodule

bind dma_direct_ch dma_direct_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_valid (mem_valid),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .en        (ctl.en),
    .len       (len_q),
    .irq       (irq),
    .clr       (cfg_wr && (cfg_addr == 3'd5) && cfg_wdata[0])
);

// File: tb/dma_direct_ch_bench.sv
// Directed bench for the DMA channel: one task per scenario, byte-array
// memory model with programmable wait states.
module dma_direct_ch_bench;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int CMD_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [2:0]        cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              dma_req = 1'b0;
    logic              dma_req_eof = 1'b0;
    logic [CMD_W-1:0]  periph_status = '0;
    logic [CMD_W-1:0]  periph_cmd;
    logic              mem_valid, mem_we, mem_ready, irq;
    logic [1:0]        mem_size;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [7:0] mem [256];
    int         wr_count;
    int         wait_cfg = 0;
    int         wcnt;

    always #4 clk = ~clk;   // 125 MHz

    dma_direct_ch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CMD_W(CMD_W)) u_dma_direct_ch (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dma_req(dma_req),
        .dma_req_eof(dma_req_eof), .periph_status(periph_status),
        .periph_cmd(periph_cmd), .mem_valid(mem_valid), .mem_we(mem_we),
        .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .irq(irq)
    );

    function automatic logic [7:0] iv(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 1;
    endfunction

    // Memory model: ready after wait_cfg stall cycles, little-endian bytes.
    assign mem_ready = mem_valid && (wcnt == wait_cfg);
    assign mem_rdata = {mem[8'(mem_addr + 3)], mem[8'(mem_addr + 2)],
                        mem[8'(mem_addr + 1)], mem[8'(mem_addr[7:0])]};

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= iv(i);
            wr_count <= 0;
            wcnt     <= 0;
        end else begin
            wcnt <= (mem_valid && !mem_ready) ? wcnt + 1 : 0;
            if (mem_valid && mem_we && mem_ready) begin
                for (int j = 0; j < nbytes(mem_size); j++)
                    mem[8'(mem_addr + ADDR_W'(j))] <= mem_wdata[8*j +: 8];
                wr_count <= wr_count + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int k = 0; k < 80; k++) begin
            rreg(3'd5, s);
            if (!s[1]) break;
            @(negedge clk);
        end
    endtask

    task automatic pulse(input logic r, input logic e);
        @(negedge clk);
        dma_req = r; dma_req_eof = e;
        @(negedge clk);
        dma_req = 1'b0; dma_req_eof = 1'b0;
        wait_idle();
    endtask

    task automatic setup(input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] n, input logic [31:0] w,
                         input logic [31:0] c);
        wreg(3'd0, s); wreg(3'd1, d); wreg(3'd2, n); wreg(3'd3, w); wreg(3'd4, c);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 6; a++) begin
            rreg(3'(a), v);
            chk("R1 reset register", v, 32'h0);
        end
        chk("R1 reset irq", {31'h0, irq}, 32'h0);
        chk("R1 reset mem_valid", {31'h0, mem_valid}, 32'h0);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        int w0;
        setup(32'h10, 32'h90, 32'd2, 32'd0, 32'h28);   // byte inc/inc, en=0
        w0 = wr_count;
        pulse(1'b1, 1'b0);
        chk("R10 no write while disabled", 32'(wr_count - w0), 32'd0);
        rreg(3'd2, v); chk("R10 count unchanged while disabled", v, 32'd2);
        wreg(3'd4, 32'h29);
        pulse(1'b1, 1'b0);
        rreg(3'd2, v); chk("R10 starts after enable", v, 32'd1);
        chk("R10 one write after enable", 32'(wr_count - w0), 32'd1);
        wreg(3'd4, 32'h0);
        // count of zero with a request ends at once, no access
        setup(32'h10, 32'h90, 32'd0, 32'd0, 32'hA9);
        w0 = wr_count;
        pulse(1'b1, 1'b0);
        chk("R10 zero count no write", 32'(wr_count - w0), 32'd0);
        rreg(3'd4, v); chk("R10 zero count clears enable", v & 32'h1, 32'h0);
        chk("R8 zero count end irq with ie", {31'h0, irq}, 32'h1);
        wreg(3'd5, 32'h1);
    endtask

    task automatic t_byte_inc();
        logic [31:0] v;
        setup(32'h10, 32'h80, 32'd3, 32'd0, 32'hA9);   // byte, inc/inc, ie
        pulse(1'b1, 1'b0);
        rreg(3'd2, v); chk("R4 count after first move", v, 32'd2);
        chk("R9 zero watermark no irq", {31'h0, irq}, 32'h0);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        for (int i = 0; i < 3; i++)
            chk("R2 byte copy", {24'h0, mem[8'(32'h80 + i)]}, {24'h0, iv(32'h10 + i)});
        rreg(3'd0, v); chk("R3 source incremented", v, 32'h13);
        rreg(3'd1, v); chk("R3 destination incremented", v, 32'h83);
        rreg(3'd2, v); chk("R5 count reached zero", v, 32'd0);
        rreg(3'd4, v); chk("R5 enable cleared", v, 32'hA8);
        chk("R8 end irq with ie", {31'h0, irq}, 32'h1);
        wreg(3'd5, 32'h0);
        chk("R8 write zero keeps flag", {31'h0, irq}, 32'h1);
        wreg(3'd5, 32'h1);
        chk("R8 write one clears flag", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_word_dec();
        logic [31:0] v;
        setup(32'h40, 32'hA0, 32'd2, 32'd0, 32'h43);   // word, dst fixed, src dec
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        chk("R2 word low byte", {24'h0, mem[8'hA0]}, {24'h0, iv(32'h3E)});
        chk("R2 word high byte", {24'h0, mem[8'hA1]}, {24'h0, iv(32'h3F)});
        chk("R2 word did not spill", {24'h0, mem[8'hA2]}, {24'h0, iv(32'hA2)});
        rreg(3'd0, v); chk("R3 source decremented by 2", v, 32'h3C);
        rreg(3'd1, v); chk("R3 destination fixed", v, 32'hA0);
        chk("R8 no irq without ie or eof", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_quad_wm();
        logic [31:0] v;
        setup(32'h20, 32'hC0, 32'd3, 32'd2, 32'h8D);   // quad, dst inc, src fixed, ie
        pulse(1'b1, 1'b0);
        chk("R9 watermark irq", {31'h0, irq}, 32'h1);
        rreg(3'd4, v); chk("R9 still enabled at watermark", v & 32'h1, 32'h1);
        wreg(3'd5, 32'h1);
        pulse(1'b1, 1'b0);
        chk("R9 no irq past watermark", {31'h0, irq}, 32'h0);
        pulse(1'b1, 1'b0);
        chk("R8 end irq after quads", {31'h0, irq}, 32'h1);
        for (int j = 0; j < 4; j++)
            chk("R2 quad copy", {24'h0, mem[8'(32'hC8 + j)]}, {24'h0, iv(32'h20 + j)});
        rreg(3'd1, v); chk("R2 destination stepped by 4", v, 32'hCC);
        rreg(3'd0, v); chk("R3 source fixed", v, 32'h20);
        wreg(3'd5, 32'h1);
    endtask

    task automatic t_eof_with_req();
        logic [31:0] v;
        periph_status = 8'h3C;
        setup(32'h60, 32'hE0, 32'd5, 32'd0, 32'h129);  // byte inc/inc, eofbuf
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b1);
        rreg(3'd2, v); chk("R6 eof ends early", v, 32'd2);
        chk("R6 last move done", {24'h0, mem[8'hE2]}, {24'h0, iv(32'h62)});
        rreg(3'd4, v); chk("R7 status captured, enable cleared", v, 32'h003C_0128);
        chk("R7 command output", {24'h0, periph_cmd}, 32'h3C);
        chk("R8 eof irq without ie", {31'h0, irq}, 32'h1);
        wreg(3'd5, 32'h1);
    endtask

    task automatic t_eof_alone();
        logic [31:0] v;
        int w0;
        periph_status = 8'h55;
        setup(32'h00, 32'h70, 32'd4, 32'd0, 32'h0012_0029);  // eofbuf clear
        w0 = wr_count;
        pulse(1'b0, 1'b1);
        chk("R6 lone eof no write", 32'(wr_count - w0), 32'd0);
        rreg(3'd2, v); chk("R6 lone eof count kept", v, 32'd4);
        rreg(3'd4, v); chk("R7 no capture without flag", v, 32'h0012_0028);
        chk("R8 lone eof irq", {31'h0, irq}, 32'h1);
        wreg(3'd5, 32'h1);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        setup(32'h30, 32'hB0, 32'd2, 32'd0, 32'h0E29);
        rreg(3'd4, v); chk("R11 reserved bits read zero", v, 32'h29);
        pulse(1'b1, 1'b0);
        rreg(3'd2, v); chk("R11 transfer unaffected", v, 32'd1);
        chk("R11 data moved", {24'h0, mem[8'hB0]}, {24'h0, iv(32'h30)});
        wreg(3'd4, 32'h0);
    endtask

    task automatic t_busy_req();
        logic [31:0] v;
        int w0;
        wait_cfg = 4;
        setup(32'h50, 32'hD0, 32'd3, 32'd0, 32'h29);
        w0 = wr_count;
        @(negedge clk); dma_req = 1'b1;
        @(negedge clk); dma_req = 1'b0;
        @(negedge clk); dma_req = 1'b1;
        @(negedge clk); dma_req = 1'b0;
        wait_idle();
        chk("R4 request while busy ignored", 32'(wr_count - w0), 32'd1);
        rreg(3'd2, v); chk("R4 single decrement", v, 32'd2);
        wait_cfg = 0;
        wreg(3'd4, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_disabled();
        t_byte_inc();
        t_word_dec();
        t_quad_wm();
        t_eof_with_req();
        t_eof_alone();
        t_reserved();
        t_busy_req();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule